// File: doc/BRIEF.md
# Multi-client hash request sequencer

This block is the control sequencer in front of a shared hash engine that serves several hardware clients and one software command path. An external arbiter offers a grant with a client index. The sequencer latches that index and checks the preconditions of the client's fixed mode. Keyed clients need entropy to be ready and a valid sideloaded key. The sequencer then steers the client's message beats into the engine. For a keyed client it appends one output-length word, pulses a process strobe and waits for the engine to report absorption. A done response, marked good or failed, goes back to the latched client only.

Software can own the engine between a Start and a Done command, and its data and process strobe are forwarded only in that window. A failed precondition parks the block in an error state. In that state the latched client's beats are drained, and any final beat arriving there is recorded as rejected traffic. Software must acknowledge the error before the block runs again. Misuse of the software path is reported as a separate error class that takes precedence over the sequencing errors. An escalation input locks the block permanently.

Top module: `hash_req_seq`

## Requirements
- R1: After a synchronous reset the block is idle: no engine valid, no process strobe, no client or software ready, no done or error response, `err_valid_o` low and `lock_o` low.
- R2: In idle, a pending grant wins over a software Start command issued in the same cycle. The grant latches the client index. One cycle later `eng_mode_o` shows that client's mode (0 plain hash, 1 customizable XOF, 2 keyed).
- R3: In the check step, a keyed client with entropy not ready enters the error state and reports code 1. A keyed client with entropy ready but an invalid key passes through a key-error step, reports code 2 and then enters the error state. A non-keyed client goes straight to message transfer.
- R4: During message transfer the latched client's valid and data drive the engine, and only that client's ready follows the engine ready. All other client readies stay low, and in idle the engine sees no valid.
- R5: A final beat accepted from a keyed client is followed by the client's output-length word, held valid until the engine accepts it, and then by a one-cycle process strobe. A non-keyed client goes directly to the process strobe.
- R6: After the process strobe the block waits until `eng_absorbed_i` equals 4'hA exactly, then returns to idle. In the next cycle it gives a one-cycle done pulse to the latched client only, with its error bit low.
- R7: Software Start (command 1) in idle opens a software window. In that window software valid and data reach the engine, `sw_ready_o` follows engine ready, command 2 raises the process strobe, and command 3 (Done) returns to idle.
- R8: In the error state the latched client's ready is held high so its beats drain. When `err_ack_i` arrives, the client receives a done pulse with its error bit set in the following cycle.
- R9: A final beat (valid and last) from the latched client while in the error state sets a sticky rejected flag. The acknowledge then leads through a rejected step that reports code 3 before idle, and the flag clears on leaving that step.
- R10: Software valid outside the software window reports code 4. A software command other than none while a client operation is between check and wait reports code 5. When a software-path error and a sequencing error coincide, the software-path code is reported. All error codes appear on `err_valid_o`/`err_code_o` one cycle after their cause.
- R11: Any `esc_i` value other than 4'h5 moves the block into a lock state on the next edge, from any state. The lock state is never left. While locked, `lock_o` is high, nothing is driven to the engine and no client is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_valid_i | input | 1 | Arbiter grant pending |
| grant_idx_i | input | IW | Granted client index |
| cli_valid_i | input | N | Per-client beat valid |
| cli_last_i | input | N | Per-client final beat marker |
| cli_data_i | input | N*DW | Per-client beat data, client 0 in the low bits |
| cli_ready_o | output | N | Per-client beat ready |
| rsp_done_o | output | N | Per-client done pulse |
| rsp_err_o | output | N | Per-client failure flag, valid with done |
| sw_cmd_i | input | 2 | Software command: 0 none, 1 start, 2 process, 3 done |
| sw_valid_i | input | 1 | Software data valid |
| sw_data_i | input | DW | Software data |
| sw_ready_o | output | 1 | Software data ready |
| eng_valid_o | output | 1 | Engine data valid |
| eng_data_o | output | DW | Engine data |
| eng_ready_i | input | 1 | Engine data ready |
| eng_process_o | output | 1 | Engine process strobe |
| eng_mode_o | output | 2 | Mode of the latched client |
| eng_absorbed_i | input | 4 | Absorption indication, 4'hA means true |
| entropy_ok_i | input | 1 | Entropy ready for keyed operation |
| key_valid_i | input | 1 | Sideloaded key valid |
| err_ack_i | input | 1 | Software acknowledge of an error |
| esc_i | input | 4 | Escalation, 4'h5 means inactive |
| err_valid_o | output | 1 | Error report valid |
| err_code_o | output | 3 | Error code |
| lock_o | output | 1 | Lock state indicator |

## Verification
Engine valid, data, process strobe and all readies are combinational from the state register and the current inputs, so they are due in the same cycle as the stimulus. Done pulses, failure flags, error codes and the latched mode are registered and appear exactly one cycle after the edge that consumes their cause. The lock indicator follows the state register and is therefore high from the edge after escalation. The bench changes inputs on the falling edge, compares every output against its behavioural model just after that, and advances the model on the rising edge. Every result is thus checked in the cycle it is due and in no other.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_MSG, S_OUTLEN, S_PROC, S_WAIT,
    S_SW, S_ERR, S_KEYBAD, S_REJ, S_LOCK
  } seq_state_e;

  localparam logic [1:0] CMD_NONE  = 2'd0;
  localparam logic [1:0] CMD_START = 2'd1;
  localparam logic [1:0] CMD_PROC  = 2'd2;
  localparam logic [1:0] CMD_DONE  = 2'd3;

  localparam logic [1:0] MODE_PLAIN = 2'd0;
  localparam logic [1:0] MODE_XOF   = 2'd1;
  localparam logic [1:0] MODE_KEYED = 2'd2;

  localparam logic [3:0] MB_TRUE = 4'hA;
  localparam logic [3:0] ESC_OFF = 4'h5;

  localparam logic [2:0] E_NONE    = 3'd0;
  localparam logic [2:0] E_ENTROPY = 3'd1;
  localparam logic [2:0] E_KEY     = 3'd2;
  localparam logic [2:0] E_REJECT  = 3'd3;
  localparam logic [2:0] E_SWDATA  = 3'd4;
  localparam logic [2:0] E_SWCMD   = 3'd5;
endpackage

// File: rtl/hrs_fsm.sv
module hrs_fsm
  import hrs_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2,
  parameter logic [2*N-1:0] CLI_MODE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grant_valid_i,
  input  logic [IW-1:0]   grant_idx_i,
  input  logic [N-1:0]    cli_valid_i,
  input  logic [N-1:0]    cli_last_i,
  input  logic            eng_ready_i,
  input  logic [3:0]      eng_absorbed_i,
  input  logic            entropy_ok_i,
  input  logic            key_valid_i,
  input  logic [1:0]      sw_cmd_i,
  input  logic            err_ack_i,
  input  logic [3:0]      esc_i,
  output seq_state_e      st_o,
  output logic [IW-1:0]   idx_o,
  output logic            latch_o,
  output logic            fin_ok_o,
  output logic            fin_err_o,
  output logic [2:0]      fsm_code_o
);
  seq_state_e    st_q, st_d;
  logic [IW-1:0] idx_q;
  logic          rej_q;
  logic          sel_valid, sel_last, sel_keyed, esc_on;

  always_comb begin
    sel_valid = 1'b0;
    sel_last  = 1'b0;
    sel_keyed = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (idx_q == IW'(i)) begin
        sel_valid = cli_valid_i[i];
        sel_last  = cli_last_i[i];
        sel_keyed = (CLI_MODE[2*i +: 2] == MODE_KEYED);
      end
    end
  end

  assign esc_on = (esc_i != ESC_OFF);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: begin
        if (grant_valid_i)              st_d = S_CFG;
        else if (sw_cmd_i == CMD_START) st_d = S_SW;
      end
      S_CFG: begin
        if (sel_keyed && !entropy_ok_i)     st_d = S_ERR;
        else if (sel_keyed && !key_valid_i) st_d = S_KEYBAD;
        else                                st_d = S_MSG;
      end
      S_MSG: begin
        if (sel_valid && eng_ready_i && sel_last)
          st_d = sel_keyed ? S_OUTLEN : S_PROC;
      end
      S_OUTLEN: if (eng_ready_i) st_d = S_PROC;
      S_PROC:   st_d = S_WAIT;
      S_WAIT:   if (eng_absorbed_i == MB_TRUE) st_d = S_IDLE;
      S_SW:     if (sw_cmd_i == CMD_DONE) st_d = S_IDLE;
      S_KEYBAD: st_d = S_ERR;
      S_ERR:    if (err_ack_i) st_d = rej_q ? S_REJ : S_IDLE;
      S_REJ:    st_d = S_IDLE;
      S_LOCK:   st_d = S_LOCK;
      default:  st_d = S_LOCK;
    endcase
    if (esc_on) st_d = S_LOCK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      rej_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (latch_o) idx_q <= grant_idx_i;
      if (st_q == S_ERR && sel_valid && sel_last) rej_q <= 1'b1;
      else if (st_q == S_REJ)                    rej_q <= 1'b0;
    end
  end

  assign st_o      = st_q;
  assign idx_o     = idx_q;
  assign latch_o   = (st_q == S_IDLE) && grant_valid_i;
  assign fin_ok_o  = (st_q == S_WAIT) && (eng_absorbed_i == MB_TRUE) && !esc_on;
  assign fin_err_o = (st_q == S_ERR) && err_ack_i && !esc_on;

  always_comb begin
    fsm_code_o = E_NONE;
    if (st_q == S_CFG && sel_keyed && !entropy_ok_i) fsm_code_o = E_ENTROPY;
    else if (st_q == S_KEYBAD)                       fsm_code_o = E_KEY;
    else if (st_q == S_REJ)                          fsm_code_o = E_REJECT;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    st_q == S_LOCK |=> st_q == S_LOCK); // R11
  AST_ESC_FORCES_LOCK: assert property (@(posedge clk) disable iff (rst)
    esc_i != ESC_OFF |=> st_q == S_LOCK); // R11
  AST_WAIT_NEEDS_ABSORB: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WAIT && eng_absorbed_i != MB_TRUE) |=> (st_q == S_WAIT || st_q == S_LOCK)); // R6
  AST_OUTLEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_OUTLEN && !eng_ready_i) |=> (st_q == S_OUTLEN || st_q == S_LOCK)); // R5
  AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    grant_valid_i |-> (int'(grant_idx_i) < N)); // R2
endmodule

// File: rtl/hrs_datamux.sv
module hrs_datamux
  import hrs_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2,
  parameter int DW = 32,
  parameter logic [N*DW-1:0] OUTLEN = '0
) (
  input  seq_state_e       st_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [N-1:0]     cli_valid_i,
  input  logic [N*DW-1:0]  cli_data_i,
  input  logic [1:0]       sw_cmd_i,
  input  logic             sw_valid_i,
  input  logic [DW-1:0]    sw_data_i,
  input  logic             eng_ready_i,
  output logic             eng_valid_o,
  output logic [DW-1:0]    eng_data_o,
  output logic             eng_process_o,
  output logic [N-1:0]     cli_ready_o,
  output logic             sw_ready_o,
  output logic [2:0]       mux_code_o
);
  logic          sel_valid, app_active;
  logic [DW-1:0] sel_data, sel_outlen;

  always_comb begin
    sel_valid  = 1'b0;
    sel_data   = '0;
    sel_outlen = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_i == IW'(i)) begin
        sel_valid  = cli_valid_i[i];
        sel_data   = cli_data_i[i*DW +: DW];
        sel_outlen = OUTLEN[i*DW +: DW];
      end
    end
  end

  always_comb begin
    eng_valid_o = 1'b0;
    eng_data_o  = '0;
    case (st_i)
      S_MSG: begin
        eng_valid_o = sel_valid;
        eng_data_o  = sel_data;
      end
      S_OUTLEN: begin
        eng_valid_o = 1'b1;
        eng_data_o  = sel_outlen;
      end
      S_SW: begin
        eng_valid_o = sw_valid_i;
        eng_data_o  = sw_data_i;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < N; g++) begin : g_ready
    assign cli_ready_o[g] = (idx_i == IW'(g)) &&
                            ((st_i == S_MSG && eng_ready_i) || st_i == S_ERR);
  end

  assign sw_ready_o    = (st_i == S_SW) && eng_ready_i;
  assign eng_process_o = (st_i == S_PROC) || (st_i == S_SW && sw_cmd_i == CMD_PROC);
  assign app_active    = (st_i == S_CFG) || (st_i == S_MSG) || (st_i == S_OUTLEN) ||
                         (st_i == S_PROC) || (st_i == S_WAIT);

  always_comb begin
    mux_code_o = E_NONE;
    if (st_i != S_SW && sw_valid_i)            mux_code_o = E_SWDATA;
    else if (app_active && sw_cmd_i != CMD_NONE) mux_code_o = E_SWCMD;
  end
endmodule

// File: rtl/hrs_report.sv
module hrs_report
  import hrs_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2,
  parameter logic [2*N-1:0] CLI_MODE = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  idx_i,
  input  logic           latch_i,
  input  logic [IW-1:0]  grant_idx_i,
  input  logic           fin_ok_i,
  input  logic           fin_err_i,
  input  logic [2:0]     fsm_code_i,
  input  logic [2:0]     mux_code_i,
  output logic [N-1:0]   rsp_done_o,
  output logic [N-1:0]   rsp_err_o,
  output logic           err_valid_o,
  output logic [2:0]     err_code_o,
  output logic [1:0]     eng_mode_o
);
  logic [1:0] grant_mode;

  always_comb begin
    grant_mode = MODE_PLAIN;
    for (int i = 0; i < N; i++)
      if (grant_idx_i == IW'(i)) grant_mode = CLI_MODE[2*i +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done_o  <= '0;
      rsp_err_o   <= '0;
      err_valid_o <= 1'b0;
      err_code_o  <= E_NONE;
      eng_mode_o  <= MODE_PLAIN;
    end else begin
      for (int i = 0; i < N; i++) begin
        rsp_done_o[i] <= (idx_i == IW'(i)) && (fin_ok_i || fin_err_i);
        rsp_err_o[i]  <= (idx_i == IW'(i)) && fin_err_i;
      end
      err_valid_o <= (mux_code_i != E_NONE) || (fsm_code_i != E_NONE);
      err_code_o  <= (mux_code_i != E_NONE) ? mux_code_i : fsm_code_i;
      if (latch_i) eng_mode_o <= grant_mode;
    end
  end

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_done_o)); // R6
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (rsp_err_o & ~rsp_done_o) == '0); // R8
endmodule

// File: rtl/hash_req_seq.sv
module hash_req_seq
  import hrs_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter logic [2*N-1:0]  CLI_MODE = {MODE_XOF, MODE_PLAIN, MODE_KEYED},
  parameter logic [N*DW-1:0] OUTLEN   = {32'd128, 32'd512, 32'd256}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_valid_i,
  input  logic [IW-1:0]    grant_idx_i,
  input  logic [N-1:0]     cli_valid_i,
  input  logic [N-1:0]     cli_last_i,
  input  logic [N*DW-1:0]  cli_data_i,
  output logic [N-1:0]     cli_ready_o,
  output logic [N-1:0]     rsp_done_o,
  output logic [N-1:0]     rsp_err_o,
  input  logic [1:0]       sw_cmd_i,
  input  logic             sw_valid_i,
  input  logic [DW-1:0]    sw_data_i,
  output logic             sw_ready_o,
  output logic             eng_valid_o,
  output logic [DW-1:0]    eng_data_o,
  input  logic             eng_ready_i,
  output logic             eng_process_o,
  output logic [1:0]       eng_mode_o,
  input  logic [3:0]       eng_absorbed_i,
  input  logic             entropy_ok_i,
  input  logic             key_valid_i,
  input  logic             err_ack_i,
  input  logic [3:0]       esc_i,
  output logic             err_valid_o,
  output logic [2:0]       err_code_o,
  output logic             lock_o
);
  seq_state_e    st;
  logic [IW-1:0] idx;
  logic          latch, fin_ok, fin_err;
  logic [2:0]    fsm_code, mux_code;

  hrs_fsm #(.N(N), .IW(IW), .CLI_MODE(CLI_MODE)) u_fsm (
    .clk(clk), .rst(rst),
    .grant_valid_i(grant_valid_i), .grant_idx_i(grant_idx_i),
    .cli_valid_i(cli_valid_i), .cli_last_i(cli_last_i),
    .eng_ready_i(eng_ready_i), .eng_absorbed_i(eng_absorbed_i),
    .entropy_ok_i(entropy_ok_i), .key_valid_i(key_valid_i),
    .sw_cmd_i(sw_cmd_i), .err_ack_i(err_ack_i), .esc_i(esc_i),
    .st_o(st), .idx_o(idx), .latch_o(latch),
    .fin_ok_o(fin_ok), .fin_err_o(fin_err), .fsm_code_o(fsm_code)
  );

  hrs_datamux #(.N(N), .IW(IW), .DW(DW), .OUTLEN(OUTLEN)) u_mux (
    .st_i(st), .idx_i(idx),
    .cli_valid_i(cli_valid_i), .cli_data_i(cli_data_i),
    .sw_cmd_i(sw_cmd_i), .sw_valid_i(sw_valid_i), .sw_data_i(sw_data_i),
    .eng_ready_i(eng_ready_i),
    .eng_valid_o(eng_valid_o), .eng_data_o(eng_data_o),
    .eng_process_o(eng_process_o), .cli_ready_o(cli_ready_o),
    .sw_ready_o(sw_ready_o), .mux_code_o(mux_code)
  );

  hrs_report #(.N(N), .IW(IW), .CLI_MODE(CLI_MODE)) u_rep (
    .clk(clk), .rst(rst),
    .idx_i(idx), .latch_i(latch), .grant_idx_i(grant_idx_i),
    .fin_ok_i(fin_ok), .fin_err_i(fin_err),
    .fsm_code_i(fsm_code), .mux_code_i(mux_code),
    .rsp_done_o(rsp_done_o), .rsp_err_o(rsp_err_o),
    .err_valid_o(err_valid_o), .err_code_o(err_code_o),
    .eng_mode_o(eng_mode_o)
  );

  assign lock_o = (st == S_LOCK);

  AST_SINGLE_READY: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cli_ready_o)); // R4
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> (!eng_valid_o && cli_ready_o == '0 && !eng_process_o)); // R11
endmodule

// File: tb/hash_req_seq_tb_top.sv
module hash_req_seq_tb_top;
  localparam int M_IDLE = 0, M_CFG = 1, M_MSG = 2, M_OUTLEN = 3, M_PROC = 4,
                 M_WAIT = 5, M_SW = 6, M_ERR = 7, M_KEYBAD = 8, M_REJ = 9, M_LOCK = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        gv;
  logic [1:0]  gidx;
  logic [2:0]  cv, cl;
  logic [31:0] cd [3];
  logic [1:0]  cmd;
  logic        swv, er, ent, kv, ack;
  logic [31:0] swd;
  logic [3:0]  absb, esc;

  logic [2:0]  cli_ready, rsp_done, rsp_err;
  logic        sw_ready, eng_valid, eng_process, err_valid, lock;
  logic [31:0] eng_data;
  logic [1:0]  eng_mode;
  logic [2:0]  err_code;

  hash_req_seq dut_i (
    .clk(clk), .rst(rst), .grant_valid_i(gv), .grant_idx_i(gidx),
    .cli_valid_i(cv), .cli_last_i(cl), .cli_data_i({cd[2], cd[1], cd[0]}),
    .cli_ready_o(cli_ready), .rsp_done_o(rsp_done), .rsp_err_o(rsp_err),
    .sw_cmd_i(cmd), .sw_valid_i(swv), .sw_data_i(swd), .sw_ready_o(sw_ready),
    .eng_valid_o(eng_valid), .eng_data_o(eng_data), .eng_ready_i(er),
    .eng_process_o(eng_process), .eng_mode_o(eng_mode), .eng_absorbed_i(absb),
    .entropy_ok_i(ent), .key_valid_i(kv), .err_ack_i(ack), .esc_i(esc),
    .err_valid_o(err_valid), .err_code_o(err_code), .lock_o(lock)
  );

  int cmode [3] = '{2, 0, 1};
  int olen  [3] = '{256, 512, 128};

  int vectors = 0, fails = 0;
  bit done_flag = 0;

  int m_st, m_idx, m_mode, m_errc;
  bit m_rej, m_errv;
  bit [2:0] m_done, m_err;

  task automatic cmp(string tag, string name, longint act, longint exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic chk(string tag, string name, longint act, longint exp);
    vectors++;
    cmp(tag, name, act, exp);
  endtask

  function automatic int mux_code();
    bit active = (m_st >= M_CFG && m_st <= M_WAIT);
    if (m_st != M_SW && swv) return 4;
    if (active && cmd != 0) return 5;
    return 0;
  endfunction

  function automatic int fsm_code();
    if (m_st == M_CFG && cmode[m_idx] == 2 && !ent) return 1;
    if (m_st == M_KEYBAD) return 2;
    if (m_st == M_REJ) return 3;
    return 0;
  endfunction

  task automatic compare();
    bit ev; bit [31:0] ed; bit [2:0] erdy;
    ev = 0; ed = 0;
    case (m_st)
      M_MSG:    begin ev = cv[m_idx]; ed = cd[m_idx]; end
      M_OUTLEN: begin ev = 1; ed = olen[m_idx]; end
      M_SW:     begin ev = swv; ed = swd; end
      default: ;
    endcase
    for (int i = 0; i < 3; i++)
      erdy[i] = (i == m_idx) && ((m_st == M_MSG && er) || m_st == M_ERR);
    vectors++;
    cmp("R4", "eng_valid", eng_valid, ev);
    cmp("R4", "eng_data", eng_data, ed);
    cmp("R4", "cli_ready", cli_ready, erdy);
    cmp("R5", "eng_process", eng_process, (m_st == M_PROC) || (m_st == M_SW && cmd == 2));
    cmp("R7", "sw_ready", sw_ready, m_st == M_SW && er);
    cmp("R6", "rsp_done", rsp_done, m_done);
    cmp("R8", "rsp_err", rsp_err, m_err);
    cmp("R10", "err_valid", err_valid, m_errv);
    cmp("R10", "err_code", err_code, m_errc);
    cmp("R2", "eng_mode", eng_mode, m_mode);
    cmp("R11", "lock", lock, m_st == M_LOCK);
  endtask

  task automatic model_step();
    int nx, mc, fc;
    bit keyed, esc_on;
    keyed  = (cmode[m_idx] == 2);
    esc_on = (esc != 4'h5);
    m_done = 0; m_err = 0;
    if (!esc_on && ((m_st == M_WAIT && absb == 4'hA) || (m_st == M_ERR && ack))) begin
      m_done[m_idx] = 1;
      m_err[m_idx]  = (m_st == M_ERR);
    end
    mc = mux_code(); fc = fsm_code();
    m_errv = (mc != 0) || (fc != 0);
    m_errc = (mc != 0) ? mc : fc;
    nx = m_st;
    case (m_st)
      M_IDLE:   if (gv) nx = M_CFG; else if (cmd == 1) nx = M_SW;
      M_CFG:    nx = (keyed && !ent) ? M_ERR : (keyed && !kv) ? M_KEYBAD : M_MSG;
      M_MSG:    if (cv[m_idx] && er && cl[m_idx]) nx = keyed ? M_OUTLEN : M_PROC;
      M_OUTLEN: if (er) nx = M_PROC;
      M_PROC:   nx = M_WAIT;
      M_WAIT:   if (absb == 4'hA) nx = M_IDLE;
      M_SW:     if (cmd == 3) nx = M_IDLE;
      M_KEYBAD: nx = M_ERR;
      M_ERR:    if (ack) nx = m_rej ? M_REJ : M_IDLE;
      M_REJ:    nx = M_IDLE;
      default:  nx = M_LOCK;
    endcase
    if (esc_on) nx = M_LOCK;
    if (m_st == M_ERR && cv[m_idx] && cl[m_idx]) m_rej = 1;
    else if (m_st == M_REJ) m_rej = 0;
    if (m_st == M_IDLE && gv) begin m_idx = gidx; m_mode = cmode[gidx]; end
    m_st = nx;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic quiet();
    gv = 0; gidx = 0; cv = 0; cl = 0; cmd = 0; swv = 0; swd = 0;
    er = 1; ent = 1; kv = 1; ack = 0; absb = 4'h5; esc = 4'h5;
    for (int i = 0; i < 3; i++) cd[i] = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    quiet();
    rst = 1;
    repeat (3) @(posedge clk);
    m_st = M_IDLE; m_idx = 0; m_mode = 0; m_rej = 0;
    m_errv = 0; m_errc = 0; m_done = 0; m_err = 0;
    @(negedge clk);
    rst = 0;
    // R1 reset state
    #1;
    chk("R1", "eng_valid", eng_valid, 0);
    chk("R1", "lock", lock, 0);
    chk("R1", "err_valid", err_valid, 0);
    chk("R1", "rsp_done", rsp_done, 0);
    chk("R1", "cli_ready", cli_ready, 0);
    tick();

    // R2 grant beats software start; plain client 1
    gv = 1; gidx = 1; cmd = 1; tick();
    gv = 0; cmd = 0;
    chk("R2", "eng_mode", eng_mode, 0);
    chk("R2", "sw_ready", sw_ready, 0);
    tick();                                     // CFG -> MSG (R3 non-keyed)
    cv[1] = 1; cd[1] = 32'h1111; er = 0; cv[0] = 1; cd[0] = 32'hBAD;
    tick();                                     // R4 stall, other client ignored
    er = 1; tick();
    cd[1] = 32'h2222; tick();
    cd[1] = 32'h3333; cl[1] = 1; tick();        // last -> PROC (R5)
    cv = 0; cl = 0;
    tick();                                     // PROC -> WAIT
    absb = 4'h0; tick();
    absb = 4'hB; tick();                        // R6 not exactly true
    absb = 4'hA; tick();
    absb = 4'h5;
    chk("R6", "rsp_done", rsp_done, 3'b010);
    chk("R6", "rsp_err", rsp_err, 3'b000);
    tick();

    // keyed client 0 with output-length word (R5), software command misuse (R10)
    gv = 1; gidx = 0; tick();
    gv = 0;
    chk("R2", "eng_mode", eng_mode, 2);
    tick();                                     // CFG -> MSG
    cv[0] = 1; cd[0] = 32'hA0A0; cmd = 2; tick();
    cmd = 0;
    chk("R10", "err_code", err_code, 5);
    cl[0] = 1; cd[0] = 32'hA1A1; tick();        // -> OUTLEN
    cv = 0; cl = 0; er = 0;
    #1 chk("R5", "eng_data", eng_data, 256);
    tick(); tick();
    er = 1; tick();                             // -> PROC
    tick();                                     // -> WAIT
    absb = 4'hA; tick();
    absb = 4'h5;
    chk("R6", "rsp_done", rsp_done, 3'b001);
    tick();

    // XOF client 2
    gv = 1; gidx = 2; tick();
    gv = 0; tick();
    cv[2] = 1; cl[2] = 1; cd[2] = 32'hC2C2; tick();
    cv = 0; cl = 0; tick();
    absb = 4'hA; tick();
    absb = 4'h5; tick();

    // software window (R7)
    cmd = 1; tick();
    cmd = 0; swv = 1; swd = 32'h5A5A; er = 0; tick();
    er = 1; tick();
    swv = 0; cmd = 2; tick();
    chk("R7", "lock", lock, 0);
    cmd = 3; tick();
    cmd = 0; swv = 1; swd = 32'h77; tick();     // data outside window
    swv = 0;
    chk("R10", "err_code", err_code, 4);
    tick();

    // entropy failure (R3), late final beat rejected (R9)
    gv = 1; gidx = 0; ent = 0; tick();
    gv = 0; tick();                             // CFG -> ERR
    chk("R3", "err_code", err_code, 1);
    #1 chk("R8", "cli_ready", cli_ready, 3'b001);
    cv[0] = 1; cl[0] = 1; tick();
    cv = 0; cl = 0; tick();
    ack = 1; tick();                            // ERR -> REJ
    ack = 0;
    chk("R8", "rsp_err", rsp_err, 3'b001);
    tick();                                     // REJ -> IDLE
    chk("R9", "err_code", err_code, 3);
    ent = 1; tick();

    // software data alongside a sequencing error: software code wins (R10)
    gv = 1; gidx = 0; ent = 0; tick();
    gv = 0; swv = 1; tick();
    swv = 0;
    chk("R10", "err_code", err_code, 4);
    ack = 1; tick();
    ack = 0; ent = 1; tick();

    // invalid key (R3)
    gv = 1; gidx = 0; kv = 0; tick();
    gv = 0; tick();                             // CFG -> KEYBAD
    tick();                                     // KEYBAD -> ERR
    chk("R3", "err_code", err_code, 2);
    ack = 1; tick();
    ack = 0; kv = 1;
    chk("R8", "rsp_err", rsp_err, 3'b001);
    tick();

    // escalation (R11)
    esc = 4'h0; tick();
    esc = 4'h5;
    chk("R11", "lock", lock, 1);
    gv = 1; gidx = 1; cmd = 1; swv = 1; tick(); tick(); tick();
    #1 chk("R11", "eng_valid", eng_valid, 0);
    chk("R11", "lock", lock, 1);
    quiet(); tick();

    finish_run();
  end
endmodule